// File: doc/BRIEF.md
# Banked Register Window

This block lets a host reach a sixteen-register peripheral through an eight-byte I/O window. The window shows one of two banks of eight registers at a time. A host access carries a 3-bit offset, a read or write strobe and a byte of data. The block turns that offset, together with the current bank, into a 4-bit register index for the peripheral. It then forwards the strobe and, for reads, returns the peripheral's byte to the host.

The bank is chosen by one bit, the top bit of the byte at offset 7. Offset 7 is present in both banks, so the host can always reach the selector whichever bank is showing. The selector is not a register of its own. It takes over a reserved high bit of the two registers that sit at offset 7. A write to offset 7 sets the bank, and the other seven bits of that write go to the register mapped at offset 7 in the current bank. A read of offset 7 returns the bank bit in bit 7 and the peripheral's lower seven bits below it.

The request to the peripheral is registered. Read data comes back to the host one cycle after the peripheral read strobe, marked by a one-cycle valid pulse.

Top module: `banked_reg_window`

## Requirements
- R1: After a synchronous reset, the bank bit is 0 (the low bank is visible), `per_rd`, `per_wr` and `host_rvalid` are 0, and `host_rdata` and `per_wdata` are 0.
- R2: With the bank bit at 0, host offsets 0,1,2,3,4,5,6,7 reach peripheral indices 0,1,2,3,11,5,10,6. In order these are data, master control, interrupt enable, interrupt identification, receive FIFO status, receive control, transmit FIFO status and transmit control.
- R3: With the bank bit at 1, host offsets 0,1,2,3,4,5,6,7 reach peripheral indices 12,8,9,7,4,13,14,15. These are: spare, divisor low, divisor high, slow clock, carrier frequency, wake-up length, wake-up data and wake-up power.
- R4: A host strobe sampled at a clock edge sets the matching peripheral strobe high for exactly the next cycle, with `per_idx` (and `per_wdata` for writes) valid in that same cycle.
- R5: A write to offset 7 in either bank loads bit 7 of `host_wdata` into the bank bit. The peripheral receives that byte with bit 7 forced to 0.
- R6: A read sets `host_rvalid` high for one cycle, one cycle after `per_rd`. In that cycle `host_rdata` equals `per_rdata` as it was during the `per_rd` cycle. For offset 7, bit 7 is replaced by the bank bit.
- R7: A bank change made by a write to offset 7 applies to an access presented in the very next cycle.
- R8: A write to any offset other than 7 leaves the bank bit unchanged and forwards all eight data bits unmodified.
- R9: When `host_rd` and `host_wr` are both high, only the write is performed: `per_rd` stays 0 and no `host_rvalid` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Window offset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| host_rvalid | output | 1 | Read data valid pulse |
| per_idx | output | 4 | Peripheral register index |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_wdata | output | 8 | Peripheral write data |
| per_rdata | input | 8 | Peripheral read data |

## Verification
Two things can fall in the same cycle: a bank switch through offset 7 and the decode of the next access. The bench writes offset 7 and presents a read of another offset in the cycle right after. It checks that the new access already lands on the index of the new bank. A second collision is a read and a write strobe raised together; here the bench expects a peripheral write, no peripheral read and no valid pulse. A peripheral stub with known contents sits behind the window. The bench checks each offset's index and data against its own map and model of the stub.

// File: rtl/bw_pkg.sv
package bw_pkg;
  localparam int BW_ADDR_W = 3;
  localparam int BW_DATA_W = 8;
  localparam int BW_IDX_W  = BW_ADDR_W + 1;

  // Peripheral index for a window offset in a given bank.
  function automatic logic [BW_IDX_W-1:0] bw_map(input logic bank,
                                                 input logic [BW_ADDR_W-1:0] off);
    logic [BW_IDX_W-1:0] idx;
    case ({bank, off})
      4'b0_000: idx = 4'd0;
      4'b0_001: idx = 4'd1;
      4'b0_010: idx = 4'd2;
      4'b0_011: idx = 4'd3;
      4'b0_100: idx = 4'd11;
      4'b0_101: idx = 4'd5;
      4'b0_110: idx = 4'd10;
      4'b0_111: idx = 4'd6;
      4'b1_000: idx = 4'd12;
      4'b1_001: idx = 4'd8;
      4'b1_010: idx = 4'd9;
      4'b1_011: idx = 4'd7;
      4'b1_100: idx = 4'd4;
      4'b1_101: idx = 4'd13;
      4'b1_110: idx = 4'd14;
      default:  idx = 4'd15;
    endcase
    return idx;
  endfunction
endpackage

// File: rtl/bw_bank_sel.sv
module bw_bank_sel (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic din,
  output logic bank
);
  always_ff @(posedge clk) begin
    if (rst)       bank <= 1'b0;
    else if (load) bank <= din;
  end

  p_bank_load_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> (bank == $past(din)));
  p_bank_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(bank));
endmodule

// File: rtl/bw_decode.sv
module bw_decode #(
  parameter int ADDR_W = bw_pkg::BW_ADDR_W,
  parameter int DATA_W = bw_pkg::BW_DATA_W,
  parameter int IDX_W  = ADDR_W + 1
) (
  input  logic              bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx,
  output logic              rd_o,
  output logic              wr_o,
  output logic              shared,
  output logic [DATA_W-1:0] wdata_o
);
  localparam logic [ADDR_W-1:0] SHARED_OFF = '1;
  localparam int SEL_BIT = DATA_W - 1;

  always_comb begin
    idx    = bw_pkg::bw_map(bank, addr);
    shared = (addr == SHARED_OFF);
    wr_o   = wr;
    rd_o   = rd & ~wr;
    wdata_o = wdata;
    if (shared) wdata_o[SEL_BIT] = 1'b0;
  end
endmodule

// File: rtl/bw_req_stage.sv
module bw_req_stage #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              shared_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rd_q,
  output logic              wr_q,
  output logic              shared_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [DATA_W-1:0] wdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      shared_q <= 1'b0;
      idx_q    <= '0;
      wdata_q  <= '0;
    end else begin
      rd_q     <= rd_i;
      wr_q     <= wr_i;
      if (rd_i || wr_i) begin
        idx_q    <= idx_i;
        shared_q <= shared_i;
      end
      if (wr_i) wdata_q <= wdata_i;
    end
  end

  p_single_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !(rd_q && wr_q));
  p_wr_follows_r4: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> wr_q);
  p_strobe_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    !(rd_i || wr_i) |=> !(rd_q || wr_q));
endmodule

// File: rtl/bw_rdata_merge.sv
module bw_rdata_merge #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_q,
  input  logic              shared_q,
  input  logic              bank,
  input  logic [DATA_W-1:0] per_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int SEL_BIT = DATA_W - 1;
  logic [DATA_W-1:0] merged;

  always_comb begin
    merged = per_rdata;
    if (shared_q) merged[SEL_BIT] = bank;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_q;
      if (rd_q) rdata <= merged;
    end
  end

  p_rvalid_after_rd_r6: assert property (@(posedge clk) disable iff (rst)
    rd_q |=> rvalid);
  p_no_spurious_rvalid_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_q |=> !rvalid);
endmodule

// File: rtl/banked_reg_window.sv
module banked_reg_window #(
  parameter int ADDR_W = bw_pkg::BW_ADDR_W,
  parameter int DATA_W = bw_pkg::BW_DATA_W,
  localparam int IDX_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic [IDX_W-1:0]  per_idx,
  output logic              per_rd,
  output logic              per_wr,
  output logic [DATA_W-1:0] per_wdata,
  input  logic [DATA_W-1:0] per_rdata
);
  localparam int SEL_BIT = DATA_W - 1;

  logic              bank;
  logic [IDX_W-1:0]  dec_idx;
  logic              dec_rd, dec_wr, dec_shared, shared_q;
  logic [DATA_W-1:0] dec_wdata;

  bw_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_decode (
    .bank(bank), .addr(host_addr), .rd(host_rd), .wr(host_wr),
    .wdata(host_wdata), .idx(dec_idx), .rd_o(dec_rd), .wr_o(dec_wr),
    .shared(dec_shared), .wdata_o(dec_wdata)
  );

  bw_bank_sel u_bank (
    .clk(clk), .rst(rst), .load(dec_wr && dec_shared),
    .din(host_wdata[SEL_BIT]), .bank(bank)
  );

  bw_req_stage #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_req (
    .clk(clk), .rst(rst), .rd_i(dec_rd), .wr_i(dec_wr),
    .shared_i(dec_shared), .idx_i(dec_idx), .wdata_i(dec_wdata),
    .rd_q(per_rd), .wr_q(per_wr), .shared_q(shared_q),
    .idx_q(per_idx), .wdata_q(per_wdata)
  );

  bw_rdata_merge #(.DATA_W(DATA_W)) u_merge (
    .clk(clk), .rst(rst), .rd_q(per_rd), .shared_q(shared_q), .bank(bank),
    .per_rdata(per_rdata), .rdata(host_rdata), .rvalid(host_rvalid)
  );

  p_rd_follows_r4: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr) |=> per_rd);
  p_rd_blocked_r9: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_wr) |=> (per_wr && !per_rd));
  p_shared_clears_top_r5: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == '1) |=> !per_wdata[SEL_BIT]);
endmodule

// File: tb/test_banked_reg_window.sv
`timescale 1ns/1ps
module test_banked_reg_window;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] host_addr;
  logic       host_rd, host_wr;
  logic [7:0] host_wdata, host_rdata, per_wdata, per_rdata;
  logic       host_rvalid, per_rd, per_wr;
  logic [3:0] per_idx;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  banked_reg_window i_banked_reg_window (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .per_idx(per_idx), .per_rd(per_rd),
    .per_wr(per_wr), .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

  // Peripheral stub: 16 bytes, synchronous write, combinational read.
  logic [7:0] stub [16];
  logic       stub_init;
  always_ff @(posedge clk) begin
    if (stub_init) begin
      for (int i = 0; i < 16; i++) stub[i] <= 8'h90 + 8'(i);
    end else if (per_wr) begin
      stub[per_idx] <= per_wdata;
    end
  end
  assign per_rdata = stub[per_idx];

  // Bench model
  logic [7:0] mmem [16];
  logic       mbank;
  task automatic model_reset();
    for (int i = 0; i < 16; i++) mmem[i] = 8'h90 + 8'(i);
    mbank = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {wr, addr[2:0], data[7:0], exp_idx[3:0]}
  localparam int NV = 26;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'h00, 4'd0},  {1'b0, 3'd1, 8'h00, 4'd1},
    {1'b0, 3'd2, 8'h00, 4'd2},  {1'b0, 3'd3, 8'h00, 4'd3},
    {1'b0, 3'd4, 8'h00, 4'd11}, {1'b0, 3'd5, 8'h00, 4'd5},
    {1'b0, 3'd6, 8'h00, 4'd10}, {1'b0, 3'd7, 8'h00, 4'd6},
    {1'b1, 3'd7, 8'h85, 4'd6},
    {1'b0, 3'd0, 8'h00, 4'd12}, {1'b0, 3'd1, 8'h00, 4'd8},
    {1'b0, 3'd2, 8'h00, 4'd9},  {1'b0, 3'd3, 8'h00, 4'd7},
    {1'b0, 3'd4, 8'h00, 4'd4},  {1'b0, 3'd5, 8'h00, 4'd13},
    {1'b0, 3'd6, 8'h00, 4'd14}, {1'b0, 3'd7, 8'h00, 4'd15},
    {1'b1, 3'd2, 8'hC3, 4'd9},  {1'b0, 3'd2, 8'h00, 4'd9},
    {1'b1, 3'd7, 8'hBC, 4'd15}, {1'b0, 3'd7, 8'h00, 4'd15},
    {1'b1, 3'd7, 8'h3C, 4'd15}, {1'b0, 3'd7, 8'h00, 4'd6},
    {1'b1, 3'd4, 8'hFF, 4'd11}, {1'b0, 3'd4, 8'h00, 4'd11},
    {1'b0, 3'd6, 8'h00, 4'd10}
  };

  task automatic idle();
    host_rd = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
  endtask

  // Single access: drive at a falling edge, check request and response.
  task automatic access(input logic wr, input logic [2:0] a, input logic [7:0] d,
                        input logic [3:0] eidx);
    logic [7:0] exp_w, exp_r;
    host_addr = a; host_wdata = d; host_wr = wr; host_rd = ~wr;
    @(negedge clk);
    idle();
    chk(wr ? "R4 per_wr" : "R4 per_rd", {30'd0, per_wr, per_rd}, wr ? 32'd2 : 32'd1);
    chk((mbank ? "R3 index" : "R2 index"), {28'd0, per_idx}, {28'd0, eidx});
    if (wr) begin
      exp_w = d;
      if (a == 3'd7) begin exp_w[7] = 1'b0; mbank = d[7]; end
      chk((a == 3'd7) ? "R5 wdata" : "R8 wdata", {24'd0, per_wdata}, {24'd0, exp_w});
      mmem[eidx] = exp_w;
      @(negedge clk);
      chk("R4 strobe ends", {30'd0, per_wr, per_rd}, 32'd0);
    end else begin
      exp_r = mmem[eidx];
      if (a == 3'd7) exp_r[7] = mbank;
      @(negedge clk);
      chk("R6 rvalid", {31'd0, host_rvalid}, 32'd1);
      chk("R6 rdata", {24'd0, host_rdata}, {24'd0, exp_r});
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1; stub_init = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 per_rd", {31'd0, per_rd}, 0);
    chk("R1 per_wr", {31'd0, per_wr}, 0);
    chk("R1 rvalid", {31'd0, host_rvalid}, 0);
    chk("R1 rdata", {24'd0, host_rdata}, 0);
    chk("R1 wdata", {24'd0, per_wdata}, 0);
    rst = 1'b0; stub_init = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      access(VEC[i][15], VEC[i][14:12], VEC[i][11:4], VEC[i][3:0]);

    // R7: bank switch then access to offset 1 in the very next cycle
    host_wr = 1'b1; host_addr = 3'd7; host_wdata = 8'h80;
    @(negedge clk);
    chk("R7 shared idx low", {28'd0, per_idx}, 32'd6);
    mmem[6] = 8'h00; mbank = 1'b1;
    host_wr = 1'b0; host_rd = 1'b1; host_addr = 3'd1;
    @(negedge clk);
    idle();
    chk("R7 next idx high", {28'd0, per_idx}, 32'd8);
    chk("R7 next is read", {30'd0, per_wr, per_rd}, 32'd1);
    @(negedge clk);
    chk("R7 rdata", {24'd0, host_rdata}, {24'd0, mmem[8]});

    // R9: read and write together
    host_rd = 1'b1; host_wr = 1'b1; host_addr = 3'd5; host_wdata = 8'h5A;
    @(negedge clk);
    idle();
    chk("R9 strobes", {30'd0, per_wr, per_rd}, 32'd2);
    chk("R9 idx", {28'd0, per_idx}, 32'd13);
    mmem[13] = 8'h5A;
    @(negedge clk);
    chk("R9 no rvalid", {31'd0, host_rvalid}, 0);
    access(1'b0, 3'd5, 8'h00, 4'd13);

    // R1: reset mid-run returns to low bank
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; mbank = 1'b0;
    @(negedge clk);
    access(1'b0, 3'd7, 8'h00, 4'd6);
    access(1'b0, 3'd1, 8'h00, 4'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule